// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block lets software drive a raw 8-bit NAND flash bus one operation at a time. Software first programs the strobe timing, the address bytes and two memory target addresses. It then writes one command word. Without further help from software, the sequencer plays a fixed series of phases. It sends a command byte with CLE high. It sends any chosen subset of five address bytes with ALE high. If asked, it waits for the ready/busy line to go low and then high again. Last, it reads a payload with RE# strobes and stores it through a plain memory-write port.

Read bytes are packed big-endian into 32-bit words. The first `MAIN_BYTES` bytes of a payload go to the main target address. Any bytes after that go to the spare target address. A status bit shows that an operation is in progress. A one-cycle `done` pulse marks its end.

The controller is a single state machine with these states: `SQ_IDLE`, `SQ_CMD`, `SQ_ADDR`, `SQ_WAIT_LO`, `SQ_WAIT_HI`, `SQ_DATA` and `SQ_DONE`. Its transitions are:
- IDLE to CMD, on a start command write.
- CMD to ADDR, when the strobe ends and the mask is not empty.
- ADDR to ADDR, while more masked bytes remain.
- CMD or ADDR to WAIT_LO, DATA or DONE, in that order of preference, once the address bytes are finished.
- WAIT_LO to WAIT_HI, when the synchronized ready/busy line is low.
- WAIT_HI to DATA or DONE, when the line is high.
- DATA to DONE, after the strobe of the last byte.
- DONE to IDLE, always.

Top module: `nand_cmd_seq`

## Requirements
- R1: A register write to offset 0x00 whose bit 31 is set starts an operation when the block is idle. While the operation runs, reading offset 0x00 returns bit 31 = 1. At the end, `done` is high for exactly one cycle and bit 31 reads 0 again.
- R2: The first bus cycle of every operation puts command-word bits 23:16 on the IO lines. During it CLE is high, ALE is low, and WE# gives one strobe.
- R3: Command bits 28:24 form the address mask. Each set bit sends one byte with ALE high, in this fixed order: bit 4 sends address register 0 (offset 0x08) bits 15:8; bit 3 sends its bits 7:0; bit 2 sends address register 1 (offset 0x0C) bits 23:16; bit 1 sends its bits 15:8; bit 0 sends its bits 7:0. A clear bit sends nothing for that byte.
- R4: When command bit 15 is set, the block waits after the address bytes. It continues only after the synchronized ready/busy input has been seen low and then high. During the wait it stays busy and issues no strobe.
- R5: A data phase runs only when command bits 13 and 12 are both 1 and the byte count in bits 11:0 is not zero. It reads exactly that many bytes, each with one RE# strobe. Each byte is sampled on the clock edge where RE# rises.
- R6: Bytes are packed big-endian: the first byte goes to bits 31:24. A word is written when it holds four bytes. A final partial word is written with its unfilled low bytes set to zero.
- R7: Memory word k goes to main target (offset 0x10) + 4k while k < `MAIN_BYTES`/4. Each later word goes to spare target (offset 0x14) + 4(k − `MAIN_BYTES`/4).
- R8: The config register is at offset 0x04. Its bits 3:0 set the low time of each strobe in clocks, and bits 7:4 set the high time. A value of 0 counts as 1. Each WE# or RE# pulse stays low for exactly the low time. Between consecutive pulses the line stays high for at least the high time.
- R9: A command write that arrives while an operation is in progress is ignored. It adds no bus cycle, and the running operation completes unchanged.
- R10: A synchronous reset returns the block to idle at once. WE# and RE# go high, CLE and ALE go low, the IO drive is released, and all registers are cleared.
- R11: WE# and RE# are never low at the same time, and CLE and ALE are never high at the same time. The IO drive is on only during command and address cycles.
- R12: Offsets 0x04, 0x08, 0x0C, 0x10 and 0x14 read back the values last written. Config reads back only its timing bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | IO byte driven to flash |
| nf_io_oe | output | 1 | IO drive enable |
| nf_io_in | input | 8 | IO byte from flash |
| nf_rb | input | 1 | Ready/busy from flash, high = ready |
| mem_valid | output | 1 | Memory write valid |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The hardest case to reach from the ports is a full 0x840-byte read that crosses from the main region into the spare region. It has to follow a ready/busy wait, and a second command write must land inside that wait. The stimulus gets there in three steps. It counts the WE# rising edges that end the command and address cycles. It holds the ready/busy line high for several cycles and, in that window, fires the rejected command and polls the status. Only then does it pulse ready/busy low and high. Separate short runs cover the remaining cases: a 6-byte partial-word read, a sparse address mask, and a reset issued in the middle of a wait.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_ADDR,
        SQ_WAIT_LO,
        SQ_WAIT_HI,
        SQ_DATA,
        SQ_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_LOW,
        ST_HIGH
    } strobe_state_t;

    localparam int REG_W      = 32;
    localparam int OFS_W      = 5;
    localparam int ADDR_SLOTS = 5;

    localparam logic [OFS_W-1:0] OFS_CMD   = 5'h00;
    localparam logic [OFS_W-1:0] OFS_CFG   = 5'h04;
    localparam logic [OFS_W-1:0] OFS_ADR0  = 5'h08;
    localparam logic [OFS_W-1:0] OFS_ADR1  = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_MAIN  = 5'h10;
    localparam logic [OFS_W-1:0] OFS_SPARE = 5'h14;

endpackage

// File: rtl/nand_strobe_gen.sv
// Produces one low/high strobe cycle each time it is enabled from ST_OFF.
module nand_strobe_gen
    import nand_seq_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [TW-1:0] low_clks,
    input  logic [TW-1:0] high_clks,
    output logic          active_low,
    output logic          last_low,
    output logic          fin
);

    strobe_state_t st;
    logic [TW-1:0] cnt;
    logic [TW-1:0] low_n;
    logic [TW-1:0] high_n;

    assign low_n  = (low_clks  == '0) ? TW'(1) : low_clks;
    assign high_n = (high_clks == '0) ? TW'(1) : high_clks;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_OFF: begin
                    if (en) begin
                        st  <= ST_LOW;
                        cnt <= low_n;
                    end
                end
                ST_LOW: begin
                    if (!en) begin
                        st <= ST_OFF;
                    end else if (cnt == TW'(1)) begin
                        st  <= ST_HIGH;
                        cnt <= high_n;
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                ST_HIGH: begin
                    if (!en || cnt == TW'(1)) begin
                        st <= ST_OFF;
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                default: st <= ST_OFF;
            endcase
        end
    end

    assign active_low = (st == ST_LOW);
    assign last_low   = (st == ST_LOW)  && (cnt == TW'(1));
    assign fin        = (st == ST_HIGH) && (cnt == TW'(1));

endmodule

// File: rtl/nand_word_packer.sv
// Collects bytes big-endian into a word; flushes on a full word or the last byte.
module nand_word_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              byte_last,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    localparam int BPW = WORD_W / 8;
    localparam int PW  = (BPW > 1) ? $clog2(BPW) : 1;

    logic [PW-1:0]     pos;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic              full;

    always_comb begin
        merged = acc;
        merged[8*(BPW-1-int'(pos)) +: 8] = byte_in;
    end

    assign full = (int'(pos) == BPW - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos      <= '0;
            acc      <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (byte_vld) begin
                if (full || byte_last) begin
                    word     <= merged;
                    word_vld <= 1'b1;
                    acc      <= '0;
                    pos      <= '0;
                end else begin
                    acc <= merged;
                    pos <= pos + PW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int TW          = 4,
    parameter int MAIN_BYTES  = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic [7:0]       nf_io_out,
    output logic             nf_io_oe,
    input  logic [7:0]       nf_io_in,
    input  logic             nf_rb,
    output logic             mem_valid,
    output logic [REG_W-1:0] mem_addr,
    output logic [REG_W-1:0] mem_data,
    output logic             done
);

    localparam int MAIN_WORDS = MAIN_BYTES / 4;
    localparam int CFG_W      = 2 * TW;
    localparam int SLOT_W     = $clog2(ADDR_SLOTS);

    seq_state_t state, state_nx;

    logic [CFG_W-1:0]      cfg_q;
    logic [REG_W-1:0]      addr0_q, addr1_q, main_q, spare_q;
    logic [ADDR_SLOTS-1:0] pend_q;
    logic [7:0]            opc_q;
    logic                  wait_q, data_q;
    logic [CNT_W-1:0]      left_q;
    logic [CNT_W-1:0]      wcnt_q;
    logic [REG_W-1:0]      ptr_q;
    logic [SYNC_STAGES-1:0] rb_sync;

    logic                  busy, start_wr, rb_s;
    logic                  stb_en, stb_low, stb_last, stb_fin;
    logic                  byte_take, word_vld;
    logic [REG_W-1:0]      word;
    logic [SLOT_W-1:0]     cur_slot;
    logic [ADDR_SLOTS-1:0] pend_nx;
    logic [7:0]            slot_byte [ADDR_SLOTS];

    // mask bit (ADDR_SLOTS-1-s) selects slot s; lowest pending slot goes first
    function automatic logic [SLOT_W-1:0] pick_slot(input logic [ADDR_SLOTS-1:0] m);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = 0; i < ADDR_SLOTS; i++) begin
            if (m[i]) r = SLOT_W'(ADDR_SLOTS - 1 - i);
        end
        return r;
    endfunction

    assign busy     = (state != SQ_IDLE);
    assign start_wr = reg_wr && (reg_addr == OFS_CMD) && reg_wdata[31] && !busy;
    assign rb_s     = rb_sync[SYNC_STAGES-1];
    assign cur_slot = pick_slot(pend_q);
    assign pend_nx  = pend_q & ~(ADDR_SLOTS'(1) << (ADDR_SLOTS - 1 - int'(cur_slot)));

    always_comb begin
        slot_byte[0] = addr0_q[15:8];
        slot_byte[1] = addr0_q[7:0];
        slot_byte[2] = addr1_q[23:16];
        slot_byte[3] = addr1_q[15:8];
        slot_byte[4] = addr1_q[7:0];
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE: if (start_wr) state_nx = SQ_CMD;
            SQ_CMD: begin
                if (stb_fin) begin
                    if (pend_q != '0) state_nx = SQ_ADDR;
                    else if (wait_q)  state_nx = SQ_WAIT_LO;
                    else if (data_q)  state_nx = SQ_DATA;
                    else              state_nx = SQ_DONE;
                end
            end
            SQ_ADDR: begin
                if (stb_fin) begin
                    if (pend_nx != '0) state_nx = SQ_ADDR;
                    else if (wait_q)   state_nx = SQ_WAIT_LO;
                    else if (data_q)   state_nx = SQ_DATA;
                    else               state_nx = SQ_DONE;
                end
            end
            SQ_WAIT_LO: if (!rb_s) state_nx = SQ_WAIT_HI;
            SQ_WAIT_HI: if (rb_s)  state_nx = data_q ? SQ_DATA : SQ_DONE;
            SQ_DATA:    if (stb_fin && left_q == '0) state_nx = SQ_DONE;
            SQ_DONE:    state_nx = SQ_IDLE;
            default:    state_nx = SQ_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        nf_cle    = (state == SQ_CMD);
        nf_ale    = (state == SQ_ADDR);
        nf_io_oe  = (state == SQ_CMD) || (state == SQ_ADDR);
        nf_we_n   = !(stb_low && nf_io_oe);
        nf_re_n   = !(stb_low && (state == SQ_DATA));
        nf_io_out = 8'h00;
        if (state == SQ_CMD)  nf_io_out = opc_q;
        if (state == SQ_ADDR) nf_io_out = slot_byte[cur_slot];
        done      = (state == SQ_DONE);
        stb_en    = nf_io_oe || (state == SQ_DATA);
        byte_take = (state == SQ_DATA) && stb_last;
        mem_valid = word_vld;
        mem_data  = word;
        mem_addr  = ptr_q;
    end

    // ---------------- register file ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            addr0_q <= '0;
            addr1_q <= '0;
            main_q  <= '0;
            spare_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CFG:   cfg_q   <= reg_wdata[CFG_W-1:0];
                OFS_ADR0:  addr0_q <= reg_wdata;
                OFS_ADR1:  addr1_q <= reg_wdata;
                OFS_MAIN:  main_q  <= reg_wdata;
                OFS_SPARE: spare_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CMD:   reg_rdata = {busy, {(REG_W-1){1'b0}}};
            OFS_CFG:   reg_rdata = REG_W'(cfg_q);
            OFS_ADR0:  reg_rdata = addr0_q;
            OFS_ADR1:  reg_rdata = addr1_q;
            OFS_MAIN:  reg_rdata = main_q;
            OFS_SPARE: reg_rdata = spare_q;
            default:   reg_rdata = '0;
        endcase
    end

    // ---------------- operation datapath ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            opc_q   <= '0;
            wait_q  <= 1'b0;
            data_q  <= 1'b0;
            left_q  <= '0;
            wcnt_q  <= '0;
            ptr_q   <= '0;
            rb_sync <= '1;
        end else begin
            rb_sync <= {rb_sync[SYNC_STAGES-2:0], nf_rb};
            if (start_wr) begin
                pend_q <= reg_wdata[28:24];
                opc_q  <= reg_wdata[23:16];
                wait_q <= reg_wdata[15];
                data_q <= reg_wdata[13] && reg_wdata[12] && (reg_wdata[CNT_W-1:0] != '0);
                left_q <= reg_wdata[CNT_W-1:0];
                wcnt_q <= '0;
                ptr_q  <= main_q;
            end
            if (state == SQ_ADDR && stb_fin) pend_q <= pend_nx;
            if (byte_take) left_q <= left_q - CNT_W'(1);
            if (word_vld) begin
                wcnt_q <= wcnt_q + CNT_W'(1);
                if (int'(wcnt_q) == MAIN_WORDS - 1) ptr_q <= spare_q;
                else                                ptr_q <= ptr_q + REG_W'(4);
            end
        end
    end

    nand_strobe_gen #(.TW(TW)) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .en        (stb_en),
        .low_clks  (cfg_q[TW-1:0]),
        .high_clks (cfg_q[CFG_W-1:TW]),
        .active_low(stb_low),
        .last_low  (stb_last),
        .fin       (stb_fin)
    );

    nand_word_packer #(.WORD_W(REG_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_wr),
        .byte_vld (byte_take),
        .byte_in  (nf_io_in),
        .byte_last(left_q == CNT_W'(1)),
        .word_vld (word_vld),
        .word     (word)
    );

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
    input logic clk,
    input logic rst,
    input logic we_n,
    input logic re_n,
    input logic cle,
    input logic ale,
    input logic io_oe,
    input logic mem_valid,
    input logic done,
    input logic busy
);

    logic rst_d;

    always_ff @(posedge clk) begin
        // R10
        if (rst_d) begin
            reset_idle_chk: assert (we_n && re_n && !cle && !ale && !io_oe && !busy)
                else $error("outputs not idle after reset");
        end
        rst_d <= rst;
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    // R11
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    // R11
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !io_oe);

    // R2
    we_needs_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> (cle || ale));

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R7
    mem_in_op_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> busy);

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .we_n     (nf_we_n),
    .re_n     (nf_re_n),
    .cle      (nf_cle),
    .ale      (nf_ale),
    .io_oe    (nf_io_oe),
    .mem_valid(mem_valid),
    .done     (done),
    .busy     (busy)
);

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;

    localparam int MAIN_B = 2048;
    localparam int MAIN_W = MAIN_B / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]  nf_io_out;
    logic [7:0]  nf_io_in;
    logic        nf_rb = 1'b1;
    logic        mem_valid;
    logic [31:0] mem_addr, mem_data;
    logic        done;

    always #2.5 clk = ~clk;

    nand_cmd_seq dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
        .nf_rb(nf_rb), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    // flash read model: byte i of a payload is rd_byte(i)
    int idx = 0;
    function automatic logic [7:0] rd_byte(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction
    assign nf_io_in = rd_byte(idx);
    always @(posedge nf_re_n) idx = idx + 1;

    // programmed register values mirrored in the bench
    logic [31:0] a0, a1, mb, sb;
    int exp_low = 1, exp_high = 1;

    // scoreboard queues
    logic [9:0]  bus_q[$];
    logic [31:0] maddr_q[$];
    logic [31:0] mdata_q[$];

    int we_rises = 0, re_falls = 0, done_cnt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    logic we_prev = 1'b1, re_prev = 1'b1;
    int we_lw = 0, re_lw = 0, re_hw = 0;
    bit re_seen = 0;
    always @(negedge clk) begin
        if (!nf_we_n) we_lw++;
        else if (!we_prev) begin
            we_rises++;
            chk(we_lw == exp_low, "R8", "WE# low width", we_lw, exp_low);
            chk(nf_cle ^ nf_ale, "R11", "one latch enable", {nf_cle, nf_ale}, 0);
            if (bus_q.size() == 0)
                chk(0, "R9", "unexpected bus cycle", {nf_cle, nf_ale, nf_io_out}, 0);
            else begin
                logic [9:0] e;
                e = bus_q.pop_front();
                chk({nf_cle, nf_ale, nf_io_out} == e, e[9] ? "R2" : "R3",
                    "bus cycle", {nf_cle, nf_ale, nf_io_out}, e);
            end
            we_lw = 0;
        end
        if (!nf_re_n) begin
            if (re_prev) begin
                re_falls++;
                if (re_seen)
                    chk(re_hw >= exp_high, "R8", "RE# high width", re_hw, exp_high);
            end
            re_lw++;
            chk(nf_we_n, "R11", "WE# high while RE# low", nf_we_n, 1);
        end else begin
            if (!re_prev) begin
                chk(re_lw == exp_low, "R8", "RE# low width", re_lw, exp_low);
                re_seen = 1;
                re_hw = 0;
            end
            re_lw = 0;
            re_hw++;
        end
        if (mem_valid) begin
            if (maddr_q.size() == 0)
                chk(0, "R6", "unexpected memory write", mem_addr, 0);
            else begin
                logic [31:0] ea, ed;
                ea = maddr_q.pop_front();
                ed = mdata_q.pop_front();
                chk(mem_addr == ea, "R7", "memory address", mem_addr, ea);
                chk(mem_data == ed, "R6", "memory data", mem_data, ed);
            end
        end
        if (done) begin
            done_cnt++;
            re_seen = 0;
        end
        we_prev = nf_we_n;
        re_prev = nf_re_n;
    end

    // ---------------- driver ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_regs(input logic [31:0] cfg, input logic [31:0] x0,
                            input logic [31:0] x1, input logic [31:0] m,
                            input logic [31:0] s);
        wr(5'h04, cfg); wr(5'h08, x0); wr(5'h0C, x1); wr(5'h10, m); wr(5'h14, s);
        a0 = x0; a1 = x1; mb = m; sb = s;
        exp_low  = (cfg[3:0] == 0) ? 1 : int'(cfg[3:0]);
        exp_high = (cfg[7:4] == 0) ? 1 : int'(cfg[7:4]);
    endtask

    function automatic logic [7:0] slot_val(input int s);
        case (s)
            0: return a0[15:8];
            1: return a0[7:0];
            2: return a1[23:16];
            3: return a1[15:8];
            default: return a1[7:0];
        endcase
    endfunction

    // pushes expected cycles and writes; returns number of WE# strobes
    task automatic expect_op(input logic [31:0] cmd, output int n_str);
        int n;
        bus_q.push_back({2'b10, cmd[23:16]});
        n_str = 1;
        for (int s = 0; s < 5; s++)
            if (cmd[28 - s]) begin
                bus_q.push_back({2'b01, slot_val(s)});
                n_str++;
            end
        n = int'(cmd[11:0]);
        if (cmd[13] && cmd[12] && n != 0)
            for (int w = 0; w < (n + 3) / 4; w++) begin
                logic [31:0] d;
                for (int b = 0; b < 4; b++)
                    d[31 - 8*b -: 8] = (4*w + b < n) ? rd_byte(4*w + b) : 8'h00;
                mdata_q.push_back(d);
                maddr_q.push_back(w < MAIN_W ? mb + 32'(4*w) : sb + 32'(4*(w - MAIN_W)));
            end
    endtask

    task automatic wait_rises(input int target);
        int t = 0;
        while (we_rises < target && t < 2000) begin @(negedge clk); t++; end
    endtask

    task automatic run_op(input logic [31:0] cmd, input bit do_wait, input bit poke);
        int n_str, base, d0, rf0, t;
        logic [31:0] st;
        expect_op(cmd, n_str);
        idx = 0;
        base = we_rises; d0 = done_cnt;
        wr(5'h00, cmd);
        if (do_wait) begin
            wait_rises(base + n_str);
            rf0 = re_falls;
            repeat (8) @(negedge clk);
            if (poke) wr(5'h00, 32'h80FF_0000);   // R9: must be dropped
            rd(5'h00, st);
            chk(st[31], "R4", "busy while waiting for ready", st, 32'h8000_0000);
            chk(re_falls == rf0 && done_cnt == d0, "R4", "no progress before ready",
                re_falls - rf0, 0);
            nf_rb = 1'b0;
            repeat (4) @(negedge clk);
            nf_rb = 1'b1;
        end
        t = 0;
        while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
        chk(done_cnt == d0 + 1, "R1", "single done pulse", done_cnt - d0, 1);
        repeat (4) @(negedge clk);
        rd(5'h00, st);
        chk(st == 0, "R1", "status idle after done", st, 0);
        chk(bus_q.size() == 0, "R3", "bus cycles outstanding", bus_q.size(), 0);
        chk(maddr_q.size() == 0, "R7", "memory writes outstanding", maddr_q.size(), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        int n_str;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_io_oe && !mem_valid && !done,
            "R10", "strobes idle after reset",
            {nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe, mem_valid, done}, 7'b1100000);
        rd(5'h00, v);
        chk(v == 0, "R10", "status after reset", v, 0);

        // R12: readback
        set_regs(32'hFFFF_FF32, 32'h0000_A1B2, 32'hC3D4_E5F6, 32'h1000_0000, 32'h2000_0000);
        rd(5'h04, v); chk(v == 32'h32, "R12", "config readback", v, 32'h32);
        rd(5'h08, v); chk(v == 32'h0000_A1B2, "R12", "addr0 readback", v, 32'h0000_A1B2);
        rd(5'h0C, v); chk(v == 32'hC3D4_E5F6, "R12", "addr1 readback", v, 32'hC3D4_E5F6);
        rd(5'h14, v); chk(v == 32'h2000_0000, "R12", "spare readback", v, 32'h2000_0000);

        // R2 R8: command byte only, low 2 high 3
        run_op(32'h80FF_0000, 0, 0);

        // R3: all five address bytes, timing zero treated as one
        set_regs(32'h0000_0000, 32'h0000_A1B2, 32'hC3D4_E5F6, 32'h1000_0000, 32'h2000_0000);
        run_op(32'h9F00_0000, 0, 0);

        // R3: sparse mask 10101
        run_op(32'h9500_0000, 0, 0);

        // R5 R6 R8: 6-byte read, partial second word, low 3 high 1
        set_regs(32'h0000_0013, 32'h0000_0102, 32'h0003_0405, 32'h0000_4000, 32'h0000_8000);
        run_op(32'h8030_3006, 0, 0);

        // R5: a missing flag or a zero count skips the data phase
        run_op(32'h8030_2006, 0, 0);
        run_op(32'h8030_1006, 0, 0);
        run_op(32'h8030_3000, 0, 0);

        // R4 R7 R9: wait for ready, full 0x840 read across main/spare, poke while busy
        set_regs(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h1000_0000, 32'h2000_0000);
        run_op(32'h8030_B840, 1, 1);

        // R4: wait without data phase, one address byte
        set_regs(32'h0000_0021, 32'h0000_0055, 32'h0000_0077, 32'h1000_0000, 32'h2000_0000);
        run_op(32'h8100_8000, 1, 0);

        // R10: reset in the middle of a wait
        expect_op(32'h8100_8000, n_str);
        begin
            int base, d0;
            base = we_rises; d0 = done_cnt;
            wr(5'h00, 32'h8100_8000);
            wait_rises(base + n_str);
            repeat (3) @(negedge clk);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_io_oe, "R10",
                "strobes idle after mid-op reset",
                {nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe}, 5'b11000);
            rd(5'h00, v); chk(v == 0, "R10", "status after mid-op reset", v, 0);
            rd(5'h08, v); chk(v == 0, "R10", "registers cleared by reset", v, 0);
            repeat (10) @(negedge clk);
            chk(done_cnt == d0, "R10", "no done after reset", done_cnt - d0, 0);
            chk(bus_q.size() == 0, "R10", "bus cycles before reset", bus_q.size(), 0);
        end

        // recovery after reset
        set_regs(32'h0000_0011, 32'h0000_1234, 32'h0056_789A, 32'h3000_0000, 32'h4000_0000);
        run_op(32'h8F00_3009, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule